// File: doc/BRIEF.md
# Authenticated MMIO Register Gate

This block sits on the memory-mapped register request path in front of an accelerator's register file. Every request enters one fixed-depth pipeline. Requests whose offset falls inside a set of guarded windows are forwarded only when the tag the gate computes over the request matches a tag the host stored in the gate beforehand. The tag binds the direction, the register offset and the write data. A request that fails the check never reaches the register file. A failed read returns a fixed word.

The host side of the protocol has three steps. First, it writes its own tag into two unguarded tag-input words with plain writes. Second, it issues the guarded access. Third, it reads back two unguarded result-tag words and a guarded status word to confirm the outcome. On a passing write, the gate publishes the tag it computed. On a passing guarded read, it runs a second tag computation over the returned data and offset and publishes that result. On a failure, the published tag keeps its old value. The hash subkey H and the encrypted initial counter block are loaded once and then reused for every transaction.

The tag is `T = ((B x H) xor L) x H xor E`. Multiplication is in GF(2^128) with the reduction polynomial x^128 + x^7 + x^2 + x + 1. Bit i of a 128-bit value is the coefficient of x^i. L is the constant 128. The block B has the following fields:

- bit 127: write flag.
- bit 126: response flag.
- bits 79:64: offset.
- bits 63:0: data, which is zero for a read request.

Top module: `mmio_auth_gate`

## Requirements
- R1: A guarded request whose stored tag equals T over its block (bit127 = write, bit126 = 0, data = write data or zero for reads) is forwarded on the register port with offset, data and direction unchanged.
- R2: An offset is guarded when, for some window i, (offset & MASK_i) == BASE_i. The default windows are base 0x0100 with mask 0xFF00, and base 0x0040 with mask 0xFFF8.
- R3: A guarded request with a wrong tag is not forwarded. If it is a read, it returns the word 0xBAD0BAD0BAD0BAD0.
- R4: A tag computed for a different offset fails, even when everything else in the block is identical.
- R5: Writes to tag-input offsets 0x0010 (low half) and 0x0018 (high half) are held inside the gate and not forwarded. They take effect for any later request in the stream, including one issued on the very next cycle.
- R6: Result-tag offsets 0x0020 (low half) and 0x0028 (high half) read the published tag. A passing guarded write publishes its request tag. A passing guarded read publishes T over {bit126 = 1, offset, returned data}. A failing or unguarded request leaves the published tag unchanged.
- R7: Status offset 0x0040 is guarded. Bit 0 of its read data is 1 when the most recent completed guarded check before this read passed, and 0 after reset or after a failure.
- R8: Every request, guarded or not, appears on the register port exactly 5 cycles after it is accepted. Its read data returns 1 cycle after that. Order is preserved.
- R9: After reset, neither output valid is asserted, and the published tag and status are zero.
- R10: The gate accepts one request per cycle with no bubbles, including back-to-back guarded requests interleaved with tag-input writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Captures cfg_h and cfg_ekj0 |
| cfg_h | input | 128 | Hash subkey H |
| cfg_ekj0 | input | 128 | Encrypted initial counter block |
| req_valid | input | 1 | Request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 16 | Register offset |
| req_wdata | input | 64 | Write data |
| reg_valid | output | 1 | Forwarded request valid |
| reg_write | output | 1 | Forwarded direction |
| reg_offset | output | 16 | Forwarded offset |
| reg_wdata | output | 64 | Forwarded write data |
| reg_rdata | input | 64 | Register file read data, valid in the same cycle as reg_valid |
| rd_valid | output | 1 | Read return valid |
| rd_data | output | 64 | Read return data |

## Verification
The bench computes every tag with its own shift-and-add field multiplier and drives a table of guarded and unguarded reads and writes. The table covers correct tags, a single flipped tag bit, and a tag made for the neighbouring offset. A design that forgot the offset in the block would forward the redirected access. A design that published on failure, or that returned register contents on a failed read, shows up in the result-tag and read-data checks after each vector.

Directed tests cover the following cases:
- Exact 5-cycle and 6-cycle latencies.
- Guarded writes issued back to back right after their tag-input writes. A gate that sampled the stored tag at entry rather than at check time would reject the second of these.
- The status word across reset, a pass and a failure.

// File: rtl/mag_pkg.sv
package mag_pkg;
    localparam int OFF_W = 16;
    localparam int DAT_W = 64;
    localparam int BLK_W = 128;
    localparam int PIPE_DEPTH = 5;

    typedef logic [BLK_W-1:0] blk_t;

    typedef struct packed {
        logic             wr;
        logic [OFF_W-1:0] off;
        logic [DAT_W-1:0] dat;
        logic             prot;
        logic             lcl;
    } req_t;

    localparam blk_t LEN_BLK = blk_t'(BLK_W);

    function automatic blk_t make_blk(input logic wr, input logic rsp,
                                      input logic [OFF_W-1:0] off,
                                      input logic [DAT_W-1:0] dat);
        blk_t b;
        b = '0;
        b[BLK_W-1] = wr;
        b[BLK_W-2] = rsp;
        b[DAT_W +: OFF_W] = off;
        b[DAT_W-1:0] = dat;
        return b;
    endfunction

    // carry-less product of a 128-bit operand with a 64-bit operand
    function automatic logic [191:0] clmul_half(input blk_t a, input logic [63:0] b);
        logic [191:0] acc;
        acc = '0;
        for (int i = 0; i < 64; i++) begin
            if (b[i]) acc = acc ^ ({64'b0, a} << i);
        end
        return acc;
    endfunction

    // fold bits 254..128 back with x^128 = x^7 + x^2 + x + 1
    function automatic blk_t gf_reduce(input logic [254:0] p);
        logic [254:0] r;
        r = p;
        for (int i = 254; i >= 128; i--) begin
            if (r[i]) begin
                r[i]       = 1'b0;
                r[i - 128] = ~r[i - 128];
                r[i - 127] = ~r[i - 127];
                r[i - 126] = ~r[i - 126];
                r[i - 121] = ~r[i - 121];
            end
        end
        return r[127:0];
    endfunction
endpackage

// File: rtl/mag_gf_mul2.sv
module mag_gf_mul2
    import mag_pkg::*;
(
    input  logic clk,
    input  blk_t a,
    input  blk_t b,
    output blk_t p
);
    logic [191:0] lo_q;
    logic [191:0] hi_q;
    logic [254:0] full;

    // stage A: two half-width partial products
    always_ff @(posedge clk) begin
        lo_q <= clmul_half(a, b[63:0]);
        hi_q <= clmul_half(a, b[127:64]);
    end

    // stage B: combine and reduce
    assign full = {63'b0, lo_q} ^ ({63'b0, hi_q} << 64);

    always_ff @(posedge clk) begin
        p <= gf_reduce(full);
    end
endmodule

// File: rtl/mag_tag_pipe.sv
module mag_tag_pipe
    import mag_pkg::*;
#(
    parameter int META_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [META_W-1:0] in_meta,
    input  blk_t              in_blk,
    input  blk_t              h,
    input  blk_t              ekj0,
    output logic [META_W-1:0] out_meta,
    output blk_t              out_tag
);
    blk_t p1, p2, x1;
    logic [META_W-1:0] m_q [PIPE_DEPTH];

    mag_gf_mul2 u_mul_a (.clk(clk), .a(in_blk), .b(h), .p(p1));
    assign x1 = p1 ^ LEN_BLK;
    mag_gf_mul2 u_mul_b (.clk(clk), .a(x1), .b(h), .p(p2));

    always_ff @(posedge clk) begin
        out_tag <= p2 ^ ekj0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_DEPTH; i++) m_q[i] <= '0;
        end else begin
            m_q[0] <= in_meta;
            for (int i = 1; i < PIPE_DEPTH; i++) m_q[i] <= m_q[i-1];
        end
    end

    assign out_meta = m_q[PIPE_DEPTH-1];
endmodule

// File: rtl/mag_prot_match.sv
module mag_prot_match
    import mag_pkg::*;
#(
    parameter int                    NREG  = 2,
    parameter logic [NREG*OFF_W-1:0] BASES = '0,
    parameter logic [NREG*OFF_W-1:0] MASKS = '0
) (
    input  logic [OFF_W-1:0] off,
    output logic             hit
);
    logic [NREG-1:0] win_hit;

    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign win_hit[g] = ((off & MASKS[g*OFF_W +: OFF_W]) == BASES[g*OFF_W +: OFF_W]);
    end

    assign hit = |win_hit;
endmodule

// File: rtl/mmio_auth_gate.sv
module mmio_auth_gate
    import mag_pkg::*;
#(
    parameter int                    NREG       = 2,
    parameter logic [NREG*OFF_W-1:0] PROT_BASE  = {16'h0040, 16'h0100},
    parameter logic [NREG*OFF_W-1:0] PROT_MASK  = {16'hFFF8, 16'hFF00},
    parameter logic [OFF_W-1:0]      TIN_LO     = 16'h0010,
    parameter logic [OFF_W-1:0]      TIN_HI     = 16'h0018,
    parameter logic [OFF_W-1:0]      TOUT_LO    = 16'h0020,
    parameter logic [OFF_W-1:0]      TOUT_HI    = 16'h0028,
    parameter logic [OFF_W-1:0]      STAT_OFF   = 16'h0040,
    parameter logic [DAT_W-1:0]      FAIL_WORD  = 64'hBAD0_BAD0_BAD0_BAD0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic [BLK_W-1:0]   cfg_h,
    input  logic [BLK_W-1:0]   cfg_ekj0,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [DAT_W-1:0]   req_wdata,
    output logic               reg_valid,
    output logic               reg_write,
    output logic [OFF_W-1:0]   reg_offset,
    output logic [DAT_W-1:0]   reg_wdata,
    input  logic [DAT_W-1:0]   reg_rdata,
    output logic               rd_valid,
    output logic [DAT_W-1:0]   rd_data
);
    localparam int REQ_W = $bits(req_t);

    blk_t h_q, ek_q, tin_q, tout_q;
    logic stat_q;

    // key material, loaded once
    always_ff @(posedge clk) begin
        if (rst) begin
            h_q  <= '0;
            ek_q <= '0;
        end else if (cfg_load) begin
            h_q  <= cfg_h;
            ek_q <= cfg_ekj0;
        end
    end

    // entry classification
    logic  in_prot, in_lcl;
    req_t  in_req;
    blk_t  in_blk;

    mag_prot_match #(.NREG(NREG), .BASES(PROT_BASE), .MASKS(PROT_MASK)) u_match (
        .off(req_offset), .hit(in_prot)
    );

    assign in_lcl = (req_offset == TIN_LO) || (req_offset == TIN_HI) ||
                    (req_offset == TOUT_LO) || (req_offset == TOUT_HI) ||
                    (req_offset == STAT_OFF);
    assign in_req = '{wr: req_write, off: req_offset, dat: req_wdata,
                      prot: in_prot, lcl: in_lcl};
    assign in_blk = make_blk(req_write, 1'b0, req_offset,
                             req_write ? req_wdata : '0);

    // request tag pipeline
    logic [REQ_W:0] s5_meta;
    blk_t           s5_tag;
    req_t           s5;
    logic           s5_v;

    mag_tag_pipe #(.META_W(REQ_W + 1)) u_req_pipe (
        .clk(clk), .rst(rst),
        .in_meta({req_valid, in_req}), .in_blk(in_blk),
        .h(h_q), .ekj0(ek_q),
        .out_meta(s5_meta), .out_tag(s5_tag)
    );

    assign s5_v = s5_meta[REQ_W];
    assign s5   = req_t'(s5_meta[REQ_W-1:0]);

    // check at the pipeline exit
    logic pass, blocked, admit;
    assign pass    = (s5_tag == tin_q);
    assign blocked = s5_v && s5.prot && !pass;
    assign admit   = s5_v && !blocked;

    assign reg_valid  = admit && !s5.lcl;
    assign reg_write  = s5.wr;
    assign reg_offset = s5.off;
    assign reg_wdata  = s5.dat;

    // local register reads
    logic [DAT_W-1:0] lcl_rd, rsp_word;
    always_comb begin
        lcl_rd = '0;
        if (s5.off == TIN_LO)   lcl_rd = tin_q[63:0];
        if (s5.off == TIN_HI)   lcl_rd = tin_q[127:64];
        if (s5.off == TOUT_LO)  lcl_rd = tout_q[63:0];
        if (s5.off == TOUT_HI)  lcl_rd = tout_q[127:64];
        if (s5.off == STAT_OFF) lcl_rd = {{(DAT_W-1){1'b0}}, stat_q};
    end
    assign rsp_word = s5.lcl ? lcl_rd : reg_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= s5_v && !s5.wr;
            rd_data  <= blocked ? FAIL_WORD : rsp_word;
        end
    end

    // response tag pipeline for passing guarded reads
    logic rsp_done;
    blk_t rsp_tag;

    mag_tag_pipe #(.META_W(1)) u_rsp_pipe (
        .clk(clk), .rst(rst),
        .in_meta(admit && s5.prot && !s5.wr),
        .in_blk(make_blk(1'b0, 1'b1, s5.off, rsp_word)),
        .h(h_q), .ekj0(ek_q),
        .out_meta(rsp_done), .out_tag(rsp_tag)
    );

    // state updates
    always_ff @(posedge clk) begin
        if (rst) begin
            tin_q  <= '0;
            tout_q <= '0;
            stat_q <= 1'b0;
        end else begin
            if (admit && s5.wr && s5.off == TIN_LO) tin_q[63:0]   <= s5.dat;
            if (admit && s5.wr && s5.off == TIN_HI) tin_q[127:64] <= s5.dat;
            if (s5_v && s5.prot) stat_q <= pass;
            // the newer request wins over an older response tag
            if (admit && s5.prot && s5.wr) tout_q <= s5_tag;
            else if (rsp_done)             tout_q <= rsp_tag;
        end
    end
endmodule

// File: rtl/mmio_auth_gate_chk.sv
module mmio_auth_gate_chk
    import mag_pkg::*;
#(
    parameter logic [DAT_W-1:0] FAIL_WORD = 64'hBAD0_BAD0_BAD0_BAD0,
    parameter logic [OFF_W-1:0] TIN_LO    = 16'h0010,
    parameter logic [OFF_W-1:0] TIN_HI    = 16'h0018
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [OFF_W-1:0] req_offset,
    input logic [DAT_W-1:0] req_wdata,
    input logic             reg_valid,
    input logic             reg_write,
    input logic [OFF_W-1:0] reg_offset,
    input logic [DAT_W-1:0] reg_wdata,
    input logic             rd_valid,
    input logic [DAT_W-1:0] rd_data,
    input logic             blocked
);
    // R8
    fwd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        reg_valid |-> ($past(req_valid, 5) && $past(req_offset, 5) == reg_offset &&
                       $past(req_write, 5) == reg_write &&
                       (!reg_write || $past(req_wdata, 5) == reg_wdata)));

    // R8
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(req_valid, 6) && !$past(req_write, 6)));

    // R3
    fail_word_chk: assert property (@(posedge clk) disable iff (rst)
        (blocked && !reg_write) |=> (rd_valid && rd_data == FAIL_WORD));

    // R5
    tagin_local_chk: assert property (@(posedge clk) disable iff (rst)
        reg_valid |-> (reg_offset != TIN_LO && reg_offset != TIN_HI));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!reg_valid && !rd_valid));
endmodule

bind mmio_auth_gate mmio_auth_gate_chk #(
    .FAIL_WORD(FAIL_WORD), .TIN_LO(TIN_LO), .TIN_HI(TIN_HI)
) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_offset(reg_offset), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .blocked(blocked)
);

// File: tb/mmio_auth_gate_bench.sv
module mmio_auth_gate_bench;
    localparam logic [127:0] HK   = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    localparam logic [127:0] EK   = 128'h58e2fccefa7e3061367f1d57a4e7455a;
    localparam logic [63:0]  FAILW = 64'hBAD0_BAD0_BAD0_BAD0;
    localparam logic [15:0]  O_TINL = 16'h0010, O_TINH = 16'h0018;
    localparam logic [15:0]  O_TOUTL = 16'h0020, O_TOUTH = 16'h0028;
    localparam logic [15:0]  O_STAT = 16'h0040;

    // vector: {write, offset, data, mode, expect_forward}
    // mode 0 unguarded, 1 correct tag, 2 flipped tag bit, 3 tag for offset^1
    localparam int NV = 10;
    localparam logic [83:0] VEC [NV] = '{
        {1'b1, 16'h0120, 64'h1111_2222_3333_4444, 2'd1, 1'b1},
        {1'b0, 16'h0130, 64'h0,                   2'd1, 1'b1},
        {1'b1, 16'h0140, 64'hDEAD_BEEF_0000_0001, 2'd2, 1'b0},
        {1'b0, 16'h0150, 64'h0,                   2'd2, 1'b0},
        {1'b1, 16'h0160, 64'h0123_4567_89AB_CDEF, 2'd3, 1'b0},
        {1'b0, 16'h0170, 64'h0,                   2'd3, 1'b0},
        {1'b1, 16'h0200, 64'hCAFE_F00D_5555_AAAA, 2'd0, 1'b1},
        {1'b0, 16'h0208, 64'h0,                   2'd0, 1'b1},
        {1'b1, 16'h0044, 64'h0000_0000_0000_0077, 2'd1, 1'b1},
        {1'b0, 16'h0046, 64'h0,                   2'd2, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic [127:0] cfg_h = '0, cfg_ekj0 = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_offset = '0;
    logic [63:0] req_wdata = '0;
    logic reg_valid, reg_write, rd_valid;
    logic [15:0] reg_offset;
    logic [63:0] reg_wdata, reg_rdata, rd_data;

    always #4 clk = ~clk;

    function automatic logic [63:0] model_rd(input logic [15:0] o);
        return 64'hC0DE_0000_0000_0000 | (64'(o) * 64'd7);
    endfunction
    assign reg_rdata = model_rd(reg_offset);

    mmio_auth_gate u_mmio_auth_gate (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_h(cfg_h), .cfg_ekj0(cfg_ekj0),
        .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
        .req_wdata(req_wdata), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_offset(reg_offset), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int n_tests = 0, n_fail = 0;
    logic [127:0] exp_tout = '0;

    // output logs
    int fwd_n = 0, rd_n = 0;
    logic        fl_w [256];
    logic [15:0] fl_o [256];
    logic [63:0] fl_d [256];
    logic [63:0] rl_d [256];

    always @(negedge clk) begin
        if (!rst) begin
            if (reg_valid && fwd_n < 256) begin
                fl_w[fwd_n] = reg_write; fl_o[fwd_n] = reg_offset; fl_d[fwd_n] = reg_wdata;
                fwd_n++;
            end
            if (rd_valid && rd_n < 256) begin
                rl_d[rd_n] = rd_data;
                rd_n++;
            end
        end
    end

    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r, x;
        r = '0; x = a;
        for (int i = 0; i < 128; i++) begin
            if (b[i]) r = r ^ x;
            x = x[127] ? ((x << 1) ^ 128'h87) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [127:0] ref_blk(input logic w, input logic rsp,
                                             input logic [15:0] o, input logic [63:0] d);
        return {w, rsp, 46'b0, o, d};
    endfunction

    function automatic logic [127:0] ref_tag(input logic [127:0] b);
        return ref_mul(ref_mul(b, HK) ^ 128'd128, HK) ^ EK;
    endfunction

    task automatic check(input logic ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic w, input logic [15:0] o, input logic [63:0] d);
        req_valid = 1'b1; req_write = w; req_offset = o; req_wdata = d;
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0; req_offset = '0; req_wdata = '0;
    endtask

    task automatic set_tagin(input logic [127:0] t);
        issue(1'b1, O_TINL, t[63:0]);
        issue(1'b1, O_TINH, t[127:64]);
    endtask

    task automatic read_any(input logic [15:0] o, output logic [63:0] d);
        int r0;
        r0 = rd_n;
        issue(1'b0, o, 64'h0);
        idle();
        repeat (14) @(negedge clk);
        check(rd_n == r0 + 1, "R8 one read return", 128'(rd_n - r0), 128'd1);
        d = rl_d[r0];
    endtask

    // correct-tag read of the status word; expects bit 0 = e
    task automatic stat_read(input logic e, input string req);
        logic [63:0] d;
        set_tagin(ref_tag(ref_blk(1'b0, 1'b0, O_STAT, 64'h0)));
        read_any(O_STAT, d);
        check(d == 64'(e), req, 128'(d), 128'(e));
        exp_tout = ref_tag(ref_blk(1'b0, 1'b1, O_STAT, 64'(e)));
    endtask

    task automatic check_tout(input string req);
        logic [63:0] lo, hi;
        read_any(O_TOUTL, lo);
        read_any(O_TOUTH, hi);
        check({hi, lo} == exp_tout, req, {hi, lo}, exp_tout);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        int f0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(!reg_valid && !rd_valid, "R9 outputs idle", {reg_valid, rd_valid}, 0);
        check_tout("R9 published tag zero after reset");
        cfg_h = HK; cfg_ekj0 = EK; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; cfg_h = '0; cfg_ekj0 = '0;
        stat_read(1'b0, "R7 R9 status zero after reset");
        stat_read(1'b1, "R7 status after pass");

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic vw, ve;
            logic [15:0] vo, to;
            logic [63:0] vd, ed;
            logic [1:0] vm;
            logic [127:0] t;
            string rq;
            int r0;
            {vw, vo, vd, vm, ve} = VEC[i];
            rq = (vm == 2'd0) ? "R8" : (vm == 2'd1) ? "R1 R2" : (vm == 2'd2) ? "R3" : "R4";
            if (vm != 2'd0) begin
                to = (vm == 2'd3) ? (vo ^ 16'h0001) : vo;
                t = ref_tag(ref_blk(vw, 1'b0, to, vw ? vd : 64'h0));
                if (vm == 2'd2) t = t ^ 128'h1;
                set_tagin(t);
            end
            f0 = fwd_n; r0 = rd_n;
            issue(vw, vo, vd);
            idle();
            repeat (14) @(negedge clk);
            check(fwd_n - f0 == int'(ve), rq, 128'(fwd_n - f0), 128'(ve));
            if (ve && fwd_n > f0) begin
                check(fl_w[f0] == vw && fl_o[f0] == vo && (!vw || fl_d[f0] == vd), rq,
                      {fl_w[f0], fl_o[f0], fl_d[f0]}, {vw, vo, vd});
            end
            if (!vw) begin
                ed = ve ? model_rd(vo) : FAILW;
                check(rd_n - r0 == 1 && rl_d[r0] == ed, rq, 128'(rl_d[r0]), 128'(ed));
            end
            if (vm != 2'd0 && ve)
                exp_tout = vw ? t : ref_tag(ref_blk(1'b0, 1'b1, vo, model_rd(vo)));
            check_tout("R6 published tag");
        end

        // R7 last vector failed
        stat_read(1'b0, "R7 status after failure");

        // R8 exact latency, unguarded write then read
        f0 = fwd_n;
        issue(1'b1, 16'h0300, 64'h0000_0000_ABCD_0001);
        idle();
        repeat (3) @(negedge clk);
        check(!reg_valid, "R8 not forwarded before 5 cycles", reg_valid, 0);
        @(negedge clk);
        check(reg_valid && reg_offset == 16'h0300, "R8 forwarded at 5 cycles",
              {reg_valid, reg_offset}, {1'b1, 16'h0300});
        repeat (4) @(negedge clk);
        issue(1'b0, 16'h0308, 64'h0);
        idle();
        repeat (4) @(negedge clk);
        check(!rd_valid, "R8 read return not before 6 cycles", rd_valid, 0);
        @(negedge clk);
        check(rd_valid && rd_data == model_rd(16'h0308), "R8 read return at 6 cycles",
              {rd_valid, rd_data}, {1'b1, model_rd(16'h0308)});
        repeat (8) @(negedge clk);

        // R10 R5 back-to-back guarded writes with tag writes between
        f0 = fwd_n;
        issue(1'b1, O_TINL, ref_tag(ref_blk(1'b1, 1'b0, 16'h0180, 64'hA1)) >> 0);
        issue(1'b1, O_TINH, 64'(ref_tag(ref_blk(1'b1, 1'b0, 16'h0180, 64'hA1)) >> 64));
        issue(1'b1, 16'h0180, 64'hA1);
        issue(1'b1, O_TINL, 64'(ref_tag(ref_blk(1'b1, 1'b0, 16'h0190, 64'hB2))));
        issue(1'b1, O_TINH, 64'(ref_tag(ref_blk(1'b1, 1'b0, 16'h0190, 64'hB2)) >> 64));
        issue(1'b1, 16'h0190, 64'hB2);
        issue(1'b1, 16'h0208, 64'hC3);
        idle();
        repeat (14) @(negedge clk);
        check(fwd_n - f0 == 3, "R10 R5 three forwarded, tag words held", 128'(fwd_n - f0), 128'd3);
        check(fl_o[f0] == 16'h0180 && fl_d[f0] == 64'hA1, "R10 first in order",
              {fl_o[f0], fl_d[f0]}, {16'h0180, 64'hA1});
        check(fl_o[f0+1] == 16'h0190 && fl_d[f0+1] == 64'hB2, "R10 second in order",
              {fl_o[f0+1], fl_d[f0+1]}, {16'h0190, 64'hB2});
        check(fl_o[f0+2] == 16'h0208 && fl_d[f0+2] == 64'hC3, "R8 R10 third in order",
              {fl_o[f0+2], fl_d[f0+2]}, {16'h0208, 64'hC3});
        exp_tout = ref_tag(ref_blk(1'b1, 1'b0, 16'h0190, 64'hB2));
        check_tout("R6 newest passing write published");

        // R5 tag-input word reads back and is not forwarded
        f0 = fwd_n;
        issue(1'b1, O_TINL, 64'h5A5A_0000_1234_9876);
        idle();
        read_any(O_TINL, d);
        check(d == 64'h5A5A_0000_1234_9876 && fwd_n == f0, "R5 tag input held locally",
              {d, 32'(fwd_n - f0)}, {64'h5A5A_0000_1234_9876, 32'd0});
        stat_read(1'b1, "R7 status after back-to-back passes");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule